// File: doc/BRIEF.md
# Clock-Stopped SPI Master Serial Port

This block is a serial port that acts as the master on an SPI link and keeps its shift clock parked low between words. The host sets a divider value, a word length and a clock-source choice, puts a word on `tx_data` and pulses `start`. The port pulls its active-low select line down and drives the top bit of the word at once. After one clock-low time it runs the shift clock for the chosen number of bits. It then holds the select line for one more full bit period and releases it.

The bit clock is built from divider ticks. A tick comes either from a fixed one-in-six prescale of the system clock or from the rising edges of an external reference that is synchronised to the system clock. One bit period lasts divider+1 ticks. Odd dividers split the period evenly. Even dividers give the high phase one tick more than the low phase. The outgoing word is shifted MSB first and changes after each rising edge. The incoming line is sampled on each falling edge. The received word is handed back right-aligned, together with a one-cycle valid pulse. The data output is a value plus an enable: the pad is high impedance whenever the enable is low.

Top module: `spi_stopclk_master`

## Requirements
- R1: After reset `sck` is 0, `ss_n` is 1, `sdo_en` is 0, `busy` is 0 and `rx_valid` is 0.
- R2: With effective divider d (the value of `cfg_div`, or 1 when `cfg_div` is 0), a bit period is d+1 ticks. The clock is high for floor(d/2)+1 ticks and low for the remaining ticks.
- R3: When `cfg_use_ext` is 0, a tick occurs once every 6 system-clock cycles from a prescaler that runs freely from reset. When it is 1, a tick occurs on each rising edge of `ext_clk` after a two-stage synchroniser. Clock edges happen only on ticks.
- R4: A `start` accepted in idle drives `ss_n` low in the following cycle. The first rising edge of `sck` comes one clock-low time (in ticks) later.
- R5: The word is sent MSB first. Bit N-1 of `tx_data` appears on `sdo` together with `ss_n` going low. The output moves to the next lower bit at each rising edge of `sck` after the first.
- R6: `miso` is sampled at each falling edge of `sck`. `rx_data` holds the N sampled bits with the first sample at bit N-1, and its upper bits are zero.
- R7: `ss_n` rises one full bit period after the last falling edge. `sdo_en` falls one clock-low time after the last falling edge and is 0 whenever `ss_n` is 1.
- R8: The word length N is `cfg_len` clamped to the range 8..32, so exactly N clock pulses occur per word.
- R9: A `start` pulse while `busy` is 1 has no effect on the word in progress, and no second word follows.
- R10: `busy` is 1 exactly while `ss_n` is 0. `rx_valid` is a single-cycle pulse in the cycle `ss_n` returns high, and `rx_data` is updated in that same cycle.
- R11: `sck` is 0 whenever `ss_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External reference clock, asynchronous |
| cfg_div | input | 8 | Bit-clock divider value, sampled at start |
| cfg_len | input | 6 | Requested word length, sampled at start |
| cfg_use_ext | input | 1 | Clock source select: 1 selects the external reference, sampled at start |
| start | input | 1 | Begin a word when idle |
| tx_data | input | 32 | Word to send, right-aligned, sampled at start |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Shift clock, idles low |
| ss_n | output | 1 | Active-low slave select |
| sdo | output | 1 | Serial data value toward the slave |
| sdo_en | output | 1 | Drive enable for sdo; 0 means high impedance |
| busy | output | 1 | Word in progress |
| rx_data | output | 32 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |

## Verification
The assertions take for granted two things. First, `ext_clk` stays high and low for at least two system-clock cycles each, so the synchroniser sees every edge. Second, the configuration inputs are only meaningful in the cycle `start` is accepted. The bench therefore toggles its reference every five cycles and changes the configuration only on the falling clock edge before a start pulse. It also keeps a reference model that counts ticks from reset and places every clock edge, the select window, the data index and the enable window by arithmetic on the elapsed tick count.

// File: rtl/spi_pkg.sv
package spi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_LAG
  } seq_state_e;

  // Divider value zero is run as one so that the low phase is never empty
  function automatic int unsigned eff_div(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int unsigned period_ticks(input int unsigned d);
    return eff_div(d) + 1;
  endfunction

  function automatic int unsigned high_ticks(input int unsigned d);
    return eff_div(d) / 2 + 1;
  endfunction

  function automatic int unsigned low_ticks(input int unsigned d);
    return period_ticks(d) - high_ticks(d);
  endfunction

  function automatic int unsigned clamp_len(input int unsigned v,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/spi_tick_src.sv
module spi_tick_src #(
  parameter int SYS_DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic use_ext,
  input  logic load,
  output logic int_tick,
  output logic ext_tick,
  output logic tick
);
  localparam int PW = (SYS_DIV > 2) ? $clog2(SYS_DIV) : 1;

  logic [PW-1:0] pre;
  logic [2:0]    sync_q;
  logic          sel_q;

  // free-running prescale of the system clock
  assign int_tick = (pre == PW'(SYS_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else if (int_tick) pre <= '0;
    else pre <= pre + PW'(1);
  end

  // two synchronising stages, third stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else sync_q <= {sync_q[1:0], ext_clk};
  end

  assign ext_tick = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else if (load) sel_q <= use_ext;
  end

  assign tick = sel_q ? ext_tick : int_tick;

  // R3: internal ticks are isolated single-cycle events
  p_int_sparse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_tick |=> !int_tick);

endmodule

// File: rtl/spi_clk_seq.sv
module spi_clk_seq
  import spi_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int NB_W  = 6,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [NB_W-1:0]  len_eff,
  output logic             sck,
  output logic             ss_n,
  output logic             sdo_en,
  output logic             busy,
  output logic             load_ev,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic             done_ev
);
  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hi_q;
  logic [CNT_W-1:0] lo_q;
  logic [CNT_W-1:0] per_q;
  logic [NB_W-1:0]  nbits_q;
  logic [NB_W-1:0]  falls;
  logic             step;
  logic             last_bit;
  logic             lag_oe_off;

  // named events for the shifter and for the assertions
  assign step       = tick && (cnt == CNT_W'(1));
  assign load_ev    = (state == ST_IDLE) && start;
  assign rise_ev    = (state == ST_LOW)  && step;
  assign fall_ev    = (state == ST_HIGH) && step;
  assign done_ev    = (state == ST_LAG)  && step;
  assign busy       = (state != ST_IDLE);
  assign last_bit   = (falls == nbits_q - NB_W'(1));
  assign lag_oe_off = (state == ST_LAG) && tick && (cnt == hi_q + CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      per_q   <= '0;
      nbits_q <= '0;
      falls   <= '0;
      sck     <= 1'b0;
      ss_n    <= 1'b1;
      sdo_en  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            hi_q    <= CNT_W'(high_ticks(32'(cfg_div)));
            lo_q    <= CNT_W'(low_ticks(32'(cfg_div)));
            per_q   <= CNT_W'(period_ticks(32'(cfg_div)));
            cnt     <= CNT_W'(low_ticks(32'(cfg_div)));
            nbits_q <= len_eff;
            falls   <= '0;
            ss_n    <= 1'b0;
            sdo_en  <= 1'b1;
            state   <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (step) begin
            sck   <= 1'b1;
            cnt   <= hi_q;
            state <= ST_HIGH;
          end else if (tick) begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_HIGH: begin
          if (step) begin
            sck <= 1'b0;
            if (last_bit) begin
              cnt   <= per_q;
              state <= ST_LAG;
            end else begin
              cnt   <= lo_q;
              falls <= falls + NB_W'(1);
              state <= ST_LOW;
            end
          end else if (tick) begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_LOW: begin
          if (step) begin
            sck   <= 1'b1;
            cnt   <= hi_q;
            state <= ST_HIGH;
          end else if (tick) begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_LAG: begin
          if (step) begin
            ss_n   <= 1'b1;
            sdo_en <= 1'b0;
            state  <= ST_IDLE;
          end else if (tick) begin
            cnt <= cnt - CNT_W'(1);
            if (lag_oe_off) sdo_en <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: no clock activity outside the select window
  p_sck_needs_select_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sck);

  // R7: data drive never enabled with select released
  p_oe_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sdo_en);

  // R3: every clock edge is caused by a divider tick
  p_sck_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck) |-> $past(tick));

  // R8: the trailing phase is entered only after the full word
  p_lag_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LAG) |-> (falls == nbits_q - NB_W'(1)));

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 32,
  parameter int NB_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ev,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              done_ev,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [NB_W-1:0]   len_eff,
  input  logic              miso,
  output logic              sdo,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;

  // the word is left-aligned so the serial bit is always the top bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_sh <= '0;
    else if (load_ev) tx_sh <= tx_data << (NB_W'(DATA_W) - len_eff);
    else if (rise_ev) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
  end

  assign sdo = tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sh <= '0;
    else if (load_ev) rx_sh <= '0;
    else if (fall_ev) rx_sh <= {rx_sh[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= done_ev;
      if (done_ev) rx_data <= rx_sh;
    end
  end

  // R10: received-word strobe lasts one cycle
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: rtl/spi_stopclk_master.sv
module spi_stopclk_master #(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 6,
  parameter int DIV_W   = 8,
  parameter int SYS_DIV = 6,
  parameter int MIN_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_use_ext,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  output logic              sck,
  output logic              ss_n,
  output logic              sdo,
  output logic              sdo_en,
  output logic              busy,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int NB_W  = $clog2(DATA_W + 1);
  localparam int CNT_W = DIV_W + 1;

  logic [NB_W-1:0] len_eff;
  logic int_tick;
  logic ext_tick;
  logic tick;
  logic load_ev;
  logic rise_ev;
  logic fall_ev;
  logic done_ev;

  assign len_eff = NB_W'(spi_pkg::clamp_len(32'(cfg_len), MIN_LEN, DATA_W));

  spi_tick_src #(.SYS_DIV(SYS_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_clk  (ext_clk),
    .use_ext  (cfg_use_ext),
    .load     (load_ev),
    .int_tick (int_tick),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  spi_clk_seq #(.DIV_W(DIV_W), .NB_W(NB_W), .CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .start   (start),
    .cfg_div (cfg_div),
    .len_eff (len_eff),
    .sck     (sck),
    .ss_n    (ss_n),
    .sdo_en  (sdo_en),
    .busy    (busy),
    .load_ev (load_ev),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .done_ev (done_ev)
  );

  spi_shifter #(.DATA_W(DATA_W), .NB_W(NB_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ev  (load_ev),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .done_ev  (done_ev),
    .tx_data  (tx_data),
    .len_eff  (len_eff),
    .miso     (miso),
    .sdo      (sdo),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  // R10: busy and the select window coincide
  p_busy_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !ss_n);

  // R5: mid-word, the data bit only moves together with a clock change
  p_sdo_moves_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(sck)) |-> $stable(sdo));

endmodule

// File: tb/test_spi_stopclk_master.sv
module test_spi_stopclk_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic [7:0]  cfg_div = 8'd0;
  logic [5:0]  cfg_len = 6'd8;
  logic        cfg_use_ext = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tx_data = 32'd0;
  logic        miso = 1'b0;
  logic        sck, ss_n, sdo, sdo_en, busy, rx_valid;
  logic [31:0] rx_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit ready = 1'b0;

  spi_stopclk_master i_spi_stopclk_master (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .cfg_div(cfg_div),
    .cfg_len(cfg_len), .cfg_use_ext(cfg_use_ext), .start(start),
    .tx_data(tx_data), .miso(miso), .sck(sck), .ss_n(ss_n), .sdo(sdo),
    .sdo_en(sdo_en), .busy(busy), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always #10 clk = ~clk;

  initial forever begin
    repeat (5) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  task automatic check(input bit ok, input string tag, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  function automatic int clampn(input int v);
    if (v < 8) return 8;
    if (v > 32) return 32;
    return v;
  endfunction

  function automatic longint maskn(input int n);
    return (longint'(1) << n) - 1;
  endfunction

  // ---------------- reference model, advanced on each rising edge -------------
  int  m_k;           // edges since reset release
  bit  m_e0, m_e1, m_e2; // sampled reference history, newest first
  bit  m_busy, m_sel, m_vld;
  int  m_p, m_L, m_H, m_T, m_N, m_F;
  longint m_tx, m_acc, m_rx;

  always @(posedge clk) begin
    bit tk_int, tk_ext, tk;
    if (!rst_n) begin
      m_k = 0; m_e0 = 0; m_e1 = 0; m_e2 = 0;
      m_busy = 0; m_sel = 0; m_vld = 0; m_p = 0; m_rx = 0; m_acc = 0;
    end else begin
      tk_int = ((m_k % 6) == 5);
      tk_ext = m_e1 && !m_e2;
      m_k++;
      m_e2 = m_e1; m_e1 = m_e0; m_e0 = ext_clk;
      tk = m_sel ? tk_ext : tk_int;
      m_vld = 0;
      if (!m_busy) begin
        if (start) begin
          int d;
          d = (cfg_div == 0) ? 1 : int'(cfg_div);
          m_T = d + 1; m_H = d / 2 + 1; m_L = m_T - m_H;
          m_N = clampn(int'(cfg_len));
          m_F = m_L + (m_N - 1) * m_T + m_H;
          m_tx = longint'(tx_data) & maskn(m_N);
          m_sel = cfg_use_ext; m_busy = 1; m_p = 0; m_acc = 0;
        end
      end else if (tk) begin
        m_p++;
        if (m_p >= m_L + m_H && m_p <= m_F && ((m_p - m_L - m_H) % m_T) == 0)
          m_acc = (m_acc << 1) | longint'(miso);
        if (m_p == m_F + m_T) begin
          m_busy = 0; m_vld = 1; m_rx = m_acc;
        end
      end
    end
  end

  // ---------------- slave responder and line monitor ----------------
  int  rises, vld_seen, slave_n;
  bit  sck_prev;
  longint captured, slave_word;

  always @(negedge clk) begin
    int idx;
    if (sck && !sck_prev) rises++;
    if (!sck && sck_prev) captured = (captured << 1) | longint'(sdo);
    if (rx_valid) vld_seen++;
    sck_prev = sck;
    idx = slave_n - 1 - ((rises > 0) ? rises - 1 : 0);
    if (idx < 0) idx = 0;
    miso = slave_word[idx];
  end

  // ---------------- per-cycle comparison against the model ----------------
  always @(negedge clk) begin
    if (ready) begin
      bit e_sck, e_en, e_sdo;
      int idx;
      e_sck = m_busy && (m_p >= m_L) && (((m_p - m_L) % m_T) < m_H) && (((m_p - m_L) / m_T) < m_N);
      e_en  = m_busy && (m_p < m_F + m_L);
      idx   = (m_p < m_L) ? 0 : (m_p - m_L) / m_T;
      if (idx > m_N - 1) idx = m_N - 1;
      e_sdo = m_tx[m_N - 1 - idx];
      check(sck == e_sck, "R2 sck", longint'(sck), longint'(e_sck));
      check(ss_n == !m_busy, "R4 ss_n", longint'(ss_n), longint'(!m_busy));
      check(sdo_en == e_en, "R7 sdo_en", longint'(sdo_en), longint'(e_en));
      if (e_en) check(sdo == e_sdo, "R5 sdo", longint'(sdo), longint'(e_sdo));
      check(busy == m_busy, "R10 busy", longint'(busy), longint'(m_busy));
      check(rx_valid == m_vld, "R10 rx_valid", longint'(rx_valid), longint'(m_vld));
      check(longint'(rx_data) == m_rx, "R6 rx_data", longint'(rx_data), m_rx);
    end
  end

  // ---------------- one word through the port ----------------
  task automatic run_word(input int div, input int len, input bit ext,
                          input logic [31:0] tx, input logic [31:0] sw,
                          input bit poke, input string tag);
    int n, guard;
    n = clampn(len);
    @(negedge clk);
    slave_n = n; slave_word = longint'(sw); rises = 0; captured = 0; vld_seen = 0;
    cfg_div = 8'(div); cfg_len = 6'(len); cfg_use_ext = ext; tx_data = tx;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      tx_data = ~tx; cfg_len = 6'd31; cfg_div = 8'd1;
      start = 1'b1;                         // R9: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    check(rises == n, {tag, " R8 pulse count"}, longint'(rises), longint'(n));
    check(captured == (longint'(tx) & maskn(n)), {tag, " R5 sent word"}, captured, longint'(tx) & maskn(n));
    check(longint'(rx_data) == (longint'(sw) & maskn(n)), {tag, " R6 received word"},
          longint'(rx_data), longint'(sw) & maskn(n));
    check(vld_seen == 1, {tag, " R10 single valid"}, longint'(vld_seen), 1);
    check(!busy && ss_n, {tag, " R9 idle after word"}, longint'(busy), 0);
  endtask

  initial begin
    slave_n = 8; slave_word = 0; rises = 0; captured = 0; vld_seen = 0; sck_prev = 0;
    repeat (4) @(negedge clk);
    // R1: reset values
    check(sck == 1'b0, "R1 sck", longint'(sck), 0);
    check(ss_n == 1'b1, "R1 ss_n", longint'(ss_n), 1);
    check(sdo_en == 1'b0, "R1 sdo_en", longint'(sdo_en), 0);
    check(busy == 1'b0, "R1 busy", longint'(busy), 0);
    check(rx_valid == 1'b0, "R1 rx_valid", longint'(rx_valid), 0);
    rst_n = 1'b1;
    ready = 1'b1;
    repeat (3) @(negedge clk);
    run_word(4, 8, 1'b0, 32'h0000_00A5, 32'h0000_003C, 1'b0, "even div");        // R2
    run_word(3, 12, 1'b0, 32'h0000_0ABC, 32'h0000_05A3, 1'b0, "odd div");        // R2
    run_word(0, 8, 1'b0, 32'h0000_0081, 32'h0000_007E, 1'b0, "zero div");        // R2
    run_word(1, 8, 1'b0, 32'h0000_0052, 32'h0000_00C9, 1'b0, "div one");         // R4
    run_word(2, 16, 1'b1, 32'h0000_1234, 32'h0000_BEEF, 1'b0, "ext clock");      // R3
    run_word(5, 3, 1'b0, 32'h0000_00F0, 32'h0000_0011, 1'b0, "short clamp");     // R8
    run_word(2, 40, 1'b0, 32'hDEAD_BEEF, 32'h0F1E_2D3C, 1'b0, "long clamp");     // R8
    run_word(6, 10, 1'b0, 32'h0000_02D5, 32'h0000_0133, 1'b1, "start while busy"); // R9
    run_word(2, 32, 1'b1, 32'h8000_0001, 32'h7FFF_FFFE, 1'b0, "ext full word");  // R3 R7
    check(sck == 1'b0 && ss_n == 1'b1, "R11 parked clock", longint'(sck), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d got=running exp=finished", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule